// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core. Instructions name sixteen registers with a 4-bit index, and the block resolves each index onto physical storage according to the processor mode that arrives on the same cycle. Exception modes therefore see private copies of some registers and the shared user copies of the rest. The banked subset depends on the mode. Some modes bank nothing. Several bank the stack pointer and link register. The fast-interrupt mode banks indices 8 to 14. The hypervisor mode banks only its stack pointer.

The block has two general read ports and one general write port. It also carries the program counter, which index 15 reaches as well, the current status word, one saved status word per exception mode, and a return-address register for the hypervisor mode. In total the block holds 43 words of 32 bits.

A mode code outside the defined set raises an illegal-mode flag, and the block then uses the user mapping. Every output is registered. A value written in cycle t can be seen on any read output after the clock edge that ends cycle t, including a read of the same physical register in that same cycle.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high, every output reads zero on the following edge, and all stored words are cleared.
- R2: User (10000) and system (11111) modes both map indices 0–14 onto the same shared user words.
- R3: The IRQ (10010), supervisor (10011), monitor (10110), abort (10111) and undefined (11011) modes each have private words for indices 13 and 14. Their other indices reach the shared user words.
- R4: Fast-interrupt mode (10001) has private words for indices 8 through 14. Indices 0–7 are shared.
- R5: Hypervisor mode (11010) has a private word for index 13 only. Its index 14 reaches the shared user word.
- R6: A read of index 15 returns the PC. A write to index 15 loads the PC and pulses `branch_taken` high on the next cycle. Without such a write, `pc_next_en` loads `pc_next` into the PC, and the general write port takes priority over it. With neither, the PC holds.
- R7: A read of the physical word being written in the same cycle returns the new data.
- R8: Each exception mode has its own saved status word. In user or system mode, a saved-status read returns zero and a write is ignored. A read or write request in those modes raises `spsr_err` on the next cycle.
- R9: In privileged modes, the status word is read and written in full. In user mode, and under an illegal code, only the application bits 31:27 and 19:16 are visible and writable.
- R10: Any mode code other than the nine listed raises `illegal_mode` on the next cycle and takes the user mapping.
- R11: The hypervisor return-address word is loaded by `elr_wr_en` in any mode and shown on `elr_rd_data` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data (registered) |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data (registered) |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| pc_next_en | input | 1 | Sequential PC update enable |
| pc_next | input | 32 | Sequential PC value |
| pc_o | output | 32 | Current PC |
| branch_taken | output | 1 | Pulse after a write to index 15 |
| cpsr_wr_en | input | 1 | Status word write enable |
| cpsr_wr_data | input | 32 | Status word write data |
| cpsr_rd_data | output | 32 | Status word as seen by the mode |
| spsr_rd_en | input | 1 | Saved-status read request |
| spsr_wr_en | input | 1 | Saved-status write enable |
| spsr_wr_data | input | 32 | Saved-status write data |
| spsr_rd_data | output | 32 | Saved status word of the current mode |
| spsr_err | output | 1 | Saved-status access without a saved word |
| elr_wr_en | input | 1 | Hypervisor return-address write enable |
| elr_wr_data | input | 32 | Hypervisor return-address write data |
| elr_rd_data | output | 32 | Hypervisor return-address word |
| illegal_mode | output | 1 | Mode code was undefined |

## Verification
The bench targets the places where the bank boundaries are uneven. Index 14 in hypervisor mode must stay on the user word: a design that banks it would leave a user write unseen. Indices 8–12 must be private in fast-interrupt mode and shared everywhere else. System mode must reach the user words while still reporting a saved-status error, and a map that treats it as an exception mode would miss either one. A read and write of the same word in the same cycle is forced often, so a design without the bypass returns stale data. The bench also drives undefined mode codes, writes to index 15 alongside `pc_next_en`, and status writes from user mode. A design that leaks privileged status bits or lets the sequential PC override a branch would fail these.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_MON, BK_HYP
  } bank_e;

  localparam int NUM_IDX      = 16;
  localparam int SHARED_GPR   = 15;
  localparam int FIQ_PRIV     = 7;
  localparam int PAIR_MODES   = 5;
  localparam int GPR_SLOTS    = SHARED_GPR + FIQ_PRIV + 2 * PAIR_MODES + 1;
  localparam int SPSR_SLOTS   = 7;
  localparam int SLOT_W       = $clog2(GPR_SLOTS);
  localparam int SPSR_W       = $clog2(SPSR_SLOTS);
  localparam int FIQ_BASE     = SHARED_GPR;
  localparam int PAIR_BASE    = FIQ_BASE + FIQ_PRIV;
  localparam int HYP_SP_SLOT  = PAIR_BASE + 2 * PAIR_MODES;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_MON = 5'b10110;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_HYP = 5'b11010;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
endpackage

// File: rtl/bregs_mode_dec.sv
module bregs_mode_dec
  import bregs_pkg::*;
(
  input  logic [4:0]        mode,
  output bank_e             bank,
  output logic              priv,
  output logic              illegal,
  output logic              has_spsr,
  output logic [SPSR_W-1:0] spsr_slot
);
  always_comb begin
    bank    = BK_USR;
    priv    = 1'b1;
    illegal = 1'b0;
    unique case (mode)
      M_USR: priv = 1'b0;
      M_SYS: bank = BK_USR;
      M_FIQ: bank = BK_FIQ;
      M_IRQ: bank = BK_IRQ;
      M_SVC: bank = BK_SVC;
      M_ABT: bank = BK_ABT;
      M_UND: bank = BK_UND;
      M_MON: bank = BK_MON;
      M_HYP: bank = BK_HYP;
      default: begin
        priv    = 1'b0;
        illegal = 1'b1;
      end
    endcase
    has_spsr  = (bank != BK_USR);
    spsr_slot = has_spsr ? SPSR_W'(bank - 3'd1) : '0;
  end
endmodule

// File: rtl/bregs_bank_map.sv
module bregs_bank_map
  import bregs_pkg::*;
(
  input  bank_e             bank,
  input  logic [3:0]        idx,
  output logic [SLOT_W-1:0] slot,
  output logic              is_pc
);
  logic [SLOT_W-1:0] pair_base;

  always_comb begin
    is_pc     = (idx == 4'd15);
    slot      = SLOT_W'(idx);
    pair_base = SLOT_W'(PAIR_BASE) + SLOT_W'(2 * (bank - BK_IRQ));
    unique case (bank)
      BK_FIQ:
        if (idx >= 4'd8 && !is_pc) slot = SLOT_W'(FIQ_BASE) + SLOT_W'(idx - 4'd8);
      BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_MON:
        if (idx == 4'd13 || idx == 4'd14) slot = pair_base + SLOT_W'(idx - 4'd13);
      BK_HYP:
        if (idx == 4'd13) slot = SLOT_W'(HYP_SP_SLOT);
      default: ;
    endcase
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] APP_MASK = 32'hF80F_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_next_en,
  input  logic [DATA_W-1:0] pc_next,
  output logic [DATA_W-1:0] pc_o,
  output logic              branch_taken,
  input  logic              cpsr_wr_en,
  input  logic [DATA_W-1:0] cpsr_wr_data,
  output logic [DATA_W-1:0] cpsr_rd_data,
  input  logic              spsr_rd_en,
  input  logic              spsr_wr_en,
  input  logic [DATA_W-1:0] spsr_wr_data,
  output logic [DATA_W-1:0] spsr_rd_data,
  output logic              spsr_err,
  input  logic              elr_wr_en,
  input  logic [DATA_W-1:0] elr_wr_data,
  output logic [DATA_W-1:0] elr_rd_data,
  output logic              illegal_mode
);
  localparam int NPORT = 3; // 0: read A, 1: read B, 2: write
  localparam logic [DATA_W-1:0] MASK = DATA_W'(APP_MASK);

  bank_e             bank;
  logic              priv, illegal, has_spsr;
  logic [SPSR_W-1:0] spsr_slot;

  bregs_mode_dec u_dec (
    .mode(mode_i), .bank(bank), .priv(priv), .illegal(illegal),
    .has_spsr(has_spsr), .spsr_slot(spsr_slot)
  );

  logic [3:0]        map_idx  [NPORT];
  logic [SLOT_W-1:0] map_slot [NPORT];
  logic              map_pc   [NPORT];

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bregs_bank_map u_map (
      .bank(bank), .idx(map_idx[p]), .slot(map_slot[p]), .is_pc(map_pc[p])
    );
  end

  logic [DATA_W-1:0] gpr  [GPR_SLOTS];
  logic [DATA_W-1:0] spsr [SPSR_SLOTS];
  logic [DATA_W-1:0] pc_q, cpsr_q;

  logic              wr_gpr, wr_pc;
  logic [DATA_W-1:0] pc_nxt, cpsr_nxt, spsr_view, a_val, b_val;

  assign wr_pc  = wr_en && map_pc[2];
  assign wr_gpr = wr_en && !map_pc[2];

  always_comb begin
    pc_nxt = wr_pc ? wr_data : (pc_next_en ? pc_next : pc_q);
    cpsr_nxt = cpsr_q;
    if (cpsr_wr_en)
      cpsr_nxt = priv ? cpsr_wr_data : ((cpsr_q & ~MASK) | (cpsr_wr_data & MASK));
    if (!has_spsr)             spsr_view = '0;
    else if (spsr_wr_en)       spsr_view = spsr_wr_data;
    else                       spsr_view = spsr[spsr_slot];
    if (map_pc[0])                              a_val = pc_nxt;
    else if (wr_gpr && map_slot[2] == map_slot[0]) a_val = wr_data;
    else                                        a_val = gpr[map_slot[0]];
    if (map_pc[1])                              b_val = pc_nxt;
    else if (wr_gpr && map_slot[2] == map_slot[1]) b_val = wr_data;
    else                                        b_val = gpr[map_slot[1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GPR_SLOTS; i++)  gpr[i]  <= '0;
      for (int i = 0; i < SPSR_SLOTS; i++) spsr[i] <= '0;
    end else begin
      if (wr_gpr)                 gpr[map_slot[2]]  <= wr_data;
      if (spsr_wr_en && has_spsr) spsr[spsr_slot]   <= spsr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      cpsr_q       <= '0;
      rd_a_data    <= '0;
      rd_b_data    <= '0;
      cpsr_rd_data <= '0;
      spsr_rd_data <= '0;
      spsr_err     <= 1'b0;
      elr_rd_data  <= '0;
      illegal_mode <= 1'b0;
      branch_taken <= 1'b0;
    end else begin
      pc_q         <= pc_nxt;
      cpsr_q       <= cpsr_nxt;
      rd_a_data    <= a_val;
      rd_b_data    <= b_val;
      cpsr_rd_data <= priv ? cpsr_nxt : (cpsr_nxt & MASK);
      spsr_rd_data <= spsr_view;
      spsr_err     <= (spsr_rd_en || spsr_wr_en) && !has_spsr;
      if (elr_wr_en) elr_rd_data <= elr_wr_data;
      illegal_mode <= illegal;
      branch_taken <= wr_pc;
    end
  end

  assign pc_o = pc_q;

  // R6
  branch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd15) |=> (branch_taken && pc_o == $past(wr_data)));
  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_idx == 4'd15) && !pc_next_en) |=> $stable(pc_o));
  // R7
  bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_a_idx) |=> (rd_a_data == $past(wr_data)));
  // R8
  spsr_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    spsr_err |-> (spsr_rd_data == '0));
  // R10
  illegal_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_mode |-> ((cpsr_rd_data & ~MASK) == '0));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam logic [31:0] AMASK = 32'hF80F_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        wr_en = 0, pc_next_en = 0, cpsr_wr_en = 0;
  logic        spsr_rd_en = 0, spsr_wr_en = 0, elr_wr_en = 0;
  logic [31:0] wr_data = '0, pc_next = '0, cpsr_wr_data = '0;
  logic [31:0] spsr_wr_data = '0, elr_wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_o, cpsr_rd_data, spsr_rd_data, elr_rd_data;
  logic        branch_taken, spsr_err, illegal_mode;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  banked_regfile uut (.*);

  // bench model: 0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,6 mon,7 hyp,8 sys,9 illegal
  logic [31:0] m_usr [15];
  logic [31:0] m_fiq [5];
  logic [31:0] m_sp  [8];
  logic [31:0] m_lr  [8];
  logic [31:0] m_sps [8];
  logic [31:0] m_pc, m_cpsr, m_elr;
  logic        m_br;

  function automatic int cls(logic [4:0] m);
    case (m)
      5'b10000: return 0; 5'b10001: return 1; 5'b10010: return 2;
      5'b10011: return 3; 5'b10111: return 4; 5'b11011: return 5;
      5'b10110: return 6; 5'b11010: return 7; 5'b11111: return 8;
      default:  return 9;
    endcase
  endfunction

  function automatic logic [31:0] mread(int b, logic [3:0] i);
    if (i == 15) return m_pc;
    if (b == 1 && i >= 8 && i <= 12) return m_fiq[i-8];
    if (i == 13 && b >= 1 && b <= 7) return m_sp[b];
    if (i == 14 && b >= 1 && b <= 6) return m_lr[b];
    return m_usr[i];
  endfunction

  task automatic mwrite(int b, logic [3:0] i, logic [31:0] d);
    if (b == 1 && i >= 8 && i <= 12) m_fiq[i-8] = d;
    else if (i == 13 && b >= 1 && b <= 7) m_sp[b] = d;
    else if (i == 14 && b >= 1 && b <= 6) m_lr[b] = d;
    else m_usr[i] = d;
  endtask

  function automatic string rtag(int b, logic [3:0] i, logic hit);
    if (i == 15) return "R6";
    if (b == 9) return "R10";
    if (hit) return "R7";
    case (b)
      0, 8: return "R2";
      1: return "R4";
      7: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: inputs already driven; update model, wait edge, compare
  task automatic step();
    int  b = cls(mode_i);
    logic priv = (b != 0 && b != 9);
    logic hasp = (b >= 1 && b <= 7);
    logic wr15 = wr_en && wr_idx == 15;
    logic ha = wr_en && wr_idx == rd_a_idx;
    logic hb = wr_en && wr_idx == rd_b_idx;
    logic perr = (spsr_rd_en || spsr_wr_en) && !hasp;
    logic [31:0] ea, eb, ec, es;
    if (wr_en && !wr15) mwrite(b, wr_idx, wr_data);
    if (wr15) m_pc = wr_data; else if (pc_next_en) m_pc = pc_next;
    m_br = wr15;
    if (cpsr_wr_en) m_cpsr = priv ? cpsr_wr_data : ((m_cpsr & ~AMASK) | (cpsr_wr_data & AMASK));
    if (spsr_wr_en && hasp) m_sps[b] = spsr_wr_data;
    if (elr_wr_en) m_elr = elr_wr_data;
    ea = mread(b, rd_a_idx);
    eb = mread(b, rd_b_idx);
    ec = priv ? m_cpsr : (m_cpsr & AMASK);
    es = hasp ? m_sps[b] : 32'h0;
    @(posedge clk); #1;
    chk(rtag(b, rd_a_idx, ha), "rd_a_data", rd_a_data, ea);
    chk(rtag(b, rd_b_idx, hb), "rd_b_data", rd_b_data, eb);
    chk("R6", "pc_o", pc_o, m_pc);
    chk("R6", "branch_taken", 32'(branch_taken), 32'(m_br));
    chk(b == 9 ? "R10" : "R9", "cpsr_rd_data", cpsr_rd_data, ec);
    chk("R8", "spsr_rd_data", spsr_rd_data, es);
    chk("R8", "spsr_err", 32'(spsr_err), 32'(perr));
    chk("R11", "elr_rd_data", elr_rd_data, m_elr);
    chk("R10", "illegal_mode", 32'(illegal_mode), 32'(b == 9));
  endtask

  task automatic idle();
    wr_en = 0; pc_next_en = 0; cpsr_wr_en = 0;
    spsr_rd_en = 0; spsr_wr_en = 0; elr_wr_en = 0;
  endtask

  task automatic put(logic [4:0] m, logic [3:0] wi, logic [31:0] d, logic [3:0] ra, logic [3:0] rb);
    @(negedge clk);
    idle(); mode_i = m; wr_en = 1; wr_idx = wi; wr_data = d; rd_a_idx = ra; rd_b_idx = rb;
    step();
  endtask

  task automatic look(logic [4:0] m, logic [3:0] ra, logic [3:0] rb);
    @(negedge clk);
    idle(); mode_i = m; rd_a_idx = ra; rd_b_idx = rb;
    step();
  endtask

  localparam logic [4:0] LEGAL [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
    5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11111};

  initial begin : watchdog
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 5; i++) m_fiq[i] = '0;
    for (int i = 0; i < 8; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sps[i] = '0; end
    m_pc = '0; m_cpsr = '0; m_elr = '0; m_br = 0;
    // R1: drive writes during reset, outputs must stay zero
    repeat (3) @(negedge clk);
    wr_en = 1; wr_idx = 4'd15; wr_data = 32'hDEAD_BEEF; cpsr_wr_en = 1; cpsr_wr_data = '1;
    @(negedge clk);
    chk("R1", "rd_a_data", rd_a_data, 0);
    chk("R1", "pc_o", pc_o, 0);
    chk("R1", "cpsr_rd_data", cpsr_rd_data, 0);
    chk("R1", "branch_taken", 32'(branch_taken), 0);
    idle(); rst = 0;

    // R3: supervisor SP private, user SP untouched
    put(5'b10011, 4'd13, 32'h5555_0013, 4'd13, 4'd0);
    look(5'b10000, 4'd13, 4'd14);
    // R4: fast-interrupt R8 private, R7 shared
    put(5'b10001, 4'd8, 32'hF1F1_0008, 4'd8, 4'd7);
    put(5'b10000, 4'd8, 32'h0000_1008, 4'd8, 4'd7);
    look(5'b10001, 4'd8, 4'd12);
    // R5: hypervisor LR shared, SP private
    put(5'b11010, 4'd14, 32'h4A4A_0014, 4'd14, 4'd13);
    look(5'b10000, 4'd14, 4'd13);
    // R2: system writes land in user copies
    put(5'b11111, 4'd13, 32'h5157_0013, 4'd13, 4'd5);
    look(5'b10000, 4'd13, 4'd5);
    // R8: saved status in system mode errors
    @(negedge clk); idle(); mode_i = 5'b11111; spsr_wr_en = 1; spsr_wr_data = 32'hABCD_0001; step();
    // R10: undefined code uses user mapping
    put(5'b00101, 4'd13, 32'h1111_EEEE, 4'd13, 4'd13);
    // R6: write 15 beats pc_next
    @(negedge clk); idle(); mode_i = 5'b10011; wr_en = 1; wr_idx = 15; wr_data = 32'h0000_8000;
    pc_next_en = 1; pc_next = 32'h0000_0004; rd_a_idx = 15; step();
    // R9: user status write keeps privileged bits
    @(negedge clk); idle(); mode_i = 5'b10011; cpsr_wr_en = 1; cpsr_wr_data = 32'h0000_00D3; step();
    @(negedge clk); idle(); mode_i = 5'b10000; cpsr_wr_en = 1; cpsr_wr_data = 32'hFFFF_FFFF; step();
    look(5'b10011, 4'd0, 4'd1);
    // R11: return address
    @(negedge clk); idle(); mode_i = 5'b10000; elr_wr_en = 1; elr_wr_data = 32'h0BAD_CAFE; step();

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      mode_i      = ($urandom % 10 == 0) ? 5'($urandom) : LEGAL[$urandom % 9];
      wr_en       = ($urandom % 2) != 0;
      wr_idx      = ($urandom % 8 == 0) ? 4'd15 : 4'($urandom % 15);
      wr_data     = $urandom;
      rd_a_idx    = ($urandom % 4 == 0) ? wr_idx : 4'($urandom);
      rd_b_idx    = ($urandom % 4 == 0) ? wr_idx : 4'($urandom);
      pc_next_en  = ($urandom % 2) != 0;
      pc_next     = $urandom;
      cpsr_wr_en  = ($urandom % 4) == 0;
      cpsr_wr_data = $urandom;
      spsr_rd_en  = ($urandom % 4) == 0;
      spsr_wr_en  = ($urandom % 4) == 0;
      spsr_wr_data = $urandom;
      elr_wr_en   = ($urandom % 6) == 0;
      elr_wr_data = $urandom;
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule